// File: doc/BRIEF.md
# Enhanced-Scan Chain with Hold Latches

This block is a parameterized scan chain used for two-vector delay testing. Every cell holds a scan flip-flop and, behind it, a hold stage that drives the logic under test. Only the hold stage output reaches that logic. While the hold stage is frozen, a new vector can be shifted into the flip-flops without disturbing the vector the logic currently sees. Any two vectors can therefore be applied back to back.

A typical test runs as follows. The first vector is shifted in, and the hold is released so that it reaches the logic and settles. The hold is then raised to freeze that vector while the second one is shifted in. Dropping the hold applies the second vector to every cell at the same edge, which creates the transitions. One rated period later, normal mode with a capture request loads the logic's responses into the flip-flops, and scan mode shifts them out.

A capture request made while the chain is in scan mode is illegal. It is flagged and has no effect on the stored state.

Top module: `scan_hold_chain`

## Requirements
- R1: After reset, all flip-flops and hold stages hold 0. `applied_vec`, `scan_out` and `mode_err` are 0.
- R2: With `shift_mode`=1 and `step_en`=1, each clock edge loads `scan_in` into cell 0 and moves cell i-1 into cell i. `scan_out` shows cell N-1, so a bit shifted in appears at `scan_out` after N shifts, and bit i of a loaded vector is shifted in as the (N-i)-th bit.
- R3: With `shift_mode`=1 and `step_en`=0, the flip-flops keep their contents.
- R4: While `hold`=0, each edge copies the flip-flop contents into the hold stages. `applied_vec` therefore follows the flip-flops one cycle later.
- R5: While `hold`=1, `applied_vec` keeps its value through shifts, captures and idle cycles.
- R6: Dropping `hold` after a new vector is loaded updates all N bits of `applied_vec` at the same edge.
- R7: With `shift_mode`=0 and `capture_req`=1, one edge loads `capture_data` bit i into cell i.
- R8: With `shift_mode`=0 and `capture_req`=0, the flip-flops keep their contents.
- R9: `mode_err` is 1 in the cycle after an edge where `shift_mode`=1 and `capture_req`=1, and 0 otherwise. That request loads no capture data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Clock enable for serial shifting |
| shift_mode | input | 1 | Test control: 1 = serial shift, 0 = parallel capture |
| hold | input | 1 | 1 freezes the hold stages, 0 lets them follow the flip-flops |
| capture_req | input | 1 | Request to load capture data |
| scan_in | input | 1 | Serial data into cell 0 |
| capture_data | input | CHAIN_LEN | Responses from the logic under test |
| applied_vec | output | CHAIN_LEN | Held vector driving the logic under test |
| scan_out | output | 1 | Serial data from cell N-1 |
| mode_err | output | 1 | Illegal capture request flag |

## Verification
On every cycle, the assertions check the shift movement, the capture load and the hold stage behaviour. A frozen hold stage must not change, and a released one must copy the flip-flops. They also check that idle and illegal requests leave the flip-flops untouched, and that the error flag tracks illegal requests. Only the bench scenarios show the full two-vector sequence end to end. These scenarios cover the order in which serial bits land in cells, that the first vector persists while the second is shifted in, that all bits launch in one step, and that captured responses return in the expected serial order. The bench sweeps every 8-bit first vector, paired with derived second vectors and responses.

// File: rtl/scan_hold_pkg.sv
package scan_hold_pkg;

   typedef enum logic [1:0] {
      OP_KEEP  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2
   } cell_op_e;

endpackage

// File: rtl/shc_mode_ctrl.sv
module shc_mode_ctrl
   import scan_hold_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     step_en,
   input  logic     shift_mode,
   input  logic     capture_req,
   output cell_op_e op,
   output logic     mode_err
);

   logic illegal_req;

   assign illegal_req = shift_mode & capture_req;

   always_comb begin
      op = OP_KEEP;
      if (shift_mode) begin
         if (step_en) op = OP_SHIFT;
      end else if (capture_req) begin
         op = OP_LOAD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_err <= 1'b0;
      else        mode_err <= illegal_req;
   end

   AST_NO_LOAD_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      shift_mode |-> (op != OP_LOAD)); // R9

endmodule

// File: rtl/shc_cell.sv
module shc_cell
   import scan_hold_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  cell_op_e op,
   input  logic     scan_d,
   input  logic     cap_d,
   input  logic     hold,
   output logic     ff_q,
   output logic     held_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ff_q <= RST_VAL;
      end else begin
         case (op)
            OP_SHIFT: ff_q <= scan_d;
            OP_LOAD:  ff_q <= cap_d;
            default:  ff_q <= ff_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     held_q <= RST_VAL;
      else if (!hold) held_q <= ff_q;
   end

endmodule

// File: rtl/shc_chain.sv
module shc_chain
   import scan_hold_pkg::*;
#(
   parameter int                    CHAIN_LEN = 8,
   parameter logic [CHAIN_LEN-1:0]  RESET_VEC = '0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  cell_op_e             op,
   input  logic                 hold,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] capture_data,
   output logic [CHAIN_LEN-1:0] ff_vec,
   output logic [CHAIN_LEN-1:0] held_vec
);

   localparam int LAST = CHAIN_LEN - 1;

   logic [CHAIN_LEN-1:0] serial_d;

   assign serial_d = {ff_vec[LAST-1:0], scan_in};

   for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_cell
      shc_cell #(.RST_VAL(RESET_VEC[g])) i_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .op    (op),
         .scan_d(serial_d[g]),
         .cap_d (capture_data[g]),
         .hold  (hold),
         .ff_q  (ff_vec[g]),
         .held_q(held_vec[g])
      );
   end

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SHIFT) |=> (ff_vec[0] == $past(scan_in))); // R2
   AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SHIFT) |=> (ff_vec[LAST:1] == $past(ff_vec[LAST-1:0]))); // R2
   AST_KEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_KEEP) |=> $stable(ff_vec)); // R3
   AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD) |=> (ff_vec == $past(capture_data))); // R7
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(held_vec)); // R5
   AST_RELEASE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> (held_vec == $past(ff_vec))); // R4

endmodule

// File: rtl/scan_hold_chain.sv
module scan_hold_chain
   import scan_hold_pkg::*;
#(
   parameter int                   CHAIN_LEN       = 8,
   parameter logic [CHAIN_LEN-1:0] RESET_VEC       = '0,
   parameter bit                   SCAN_OUT_RETIME = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_en,
   input  logic                 shift_mode,
   input  logic                 hold,
   input  logic                 capture_req,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] capture_data,
   output logic [CHAIN_LEN-1:0] applied_vec,
   output logic                 scan_out,
   output logic                 mode_err
);

   localparam int LAST = CHAIN_LEN - 1;

   if (CHAIN_LEN < 2) begin : g_len_chk
      $error("scan_hold_chain: CHAIN_LEN must be at least 2");
   end

   cell_op_e             op;
   logic [CHAIN_LEN-1:0] ff_vec;

   shc_mode_ctrl i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en),
      .shift_mode (shift_mode),
      .capture_req(capture_req),
      .op         (op),
      .mode_err   (mode_err)
   );

   shc_chain #(.CHAIN_LEN(CHAIN_LEN), .RESET_VEC(RESET_VEC)) i_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .hold        (hold),
      .scan_in     (scan_in),
      .capture_data(capture_data),
      .ff_vec      (ff_vec),
      .held_vec    (applied_vec)
   );

   if (SCAN_OUT_RETIME) begin : g_so_reg
      logic so_q;
      always_ff @(posedge clk) begin
         if (!rst_n) so_q <= 1'b0;
         else        so_q <= ff_vec[LAST];
      end
      assign scan_out = so_q;
   end else begin : g_so_dir
      assign scan_out = ff_vec[LAST];
   end

   AST_ILLEGAL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && capture_req && !step_en) |=> $stable(ff_vec)); // R9
   AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && capture_req) |=> mode_err); // R9
   AST_IDLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_mode && !capture_req) |=> $stable(ff_vec)); // R8

endmodule

// File: tb/test_scan_hold_chain.sv
module test_scan_hold_chain;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         step_en, shift_mode, hold, capture_req, scan_in;
   logic [N-1:0] capture_data;
   logic [N-1:0] applied_vec;
   logic         scan_out, mode_err;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_hold_chain #(.CHAIN_LEN(N)) i_scan_hold_chain (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .shift_mode(shift_mode),
      .hold(hold), .capture_req(capture_req), .scan_in(scan_in),
      .capture_data(capture_data), .applied_vec(applied_vec),
      .scan_out(scan_out), .mode_err(mode_err)
   );

   task automatic step();
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      step_en = 0; shift_mode = 1; capture_req = 0; scan_in = 0;
   endtask

   // bit i of v is shifted in as the (N-i)-th bit
   task automatic load(input logic [N-1:0] v, input logic [N-1:0] held_exp, input bit chk_hold);
      shift_mode = 1; step_en = 1; capture_req = 0;
      for (int k = 0; k < N; k++) begin
         scan_in = v[N-1-k];
         step();
         if (chk_hold) chk("R5 hold during shift", applied_vec, held_exp);
      end
      idle();
   endtask

   task automatic release_hold();
      hold = 0;
      step();
      hold = 1;
   endtask

   initial begin
      rst_n = 0; hold = 1; capture_data = '0;
      idle();
      step(); step();
      rst_n = 1;
      chk("R1 reset applied", applied_vec, '0);
      chk("R1 reset scan_out", {7'd0, scan_out}, '0);
      chk("R1 reset mode_err", {7'd0, mode_err}, '0);

      for (int a = 0; a < 256; a++) begin
         logic [N-1:0] v1, v2, cap;
         v1  = a[N-1:0];
         v2  = ~v1 ^ N'(a * 3);
         cap = N'(a * 37 + 11);
         load(v1, '0, 0);
         chk("R2 scan_out shows first bit", {7'd0, scan_out}, {7'd0, v1[N-1]});
         release_hold();
         chk("R4 release applies V1", applied_vec, v1);
         load(v2, v1, 1);
         chk("R5 V1 still held", applied_vec, v1);
         release_hold();
         chk("R6 launch V2", applied_vec, v2);
         shift_mode = 0; capture_req = 1; capture_data = cap;
         step();
         idle();
         chk("R5 hold during capture", applied_vec, v2);
         chk("R9 no error on legal capture", {7'd0, mode_err}, '0);
         shift_mode = 1; step_en = 1;
         for (int j = 0; j < N; j++) begin
            chk("R7 captured bit", {7'd0, scan_out}, {7'd0, cap[N-1-j]});
            step();
         end
         idle();
      end

      // R3: shift disabled keeps flip-flops
      load(8'hA5, '0, 0);
      shift_mode = 1; step_en = 0; scan_in = 1;
      step(); step(); step();
      chk("R3 scan_out stable", {7'd0, scan_out}, 8'd1);
      release_hold();
      chk("R3 contents unchanged", applied_vec, 8'hA5);

      // R8: normal mode without request keeps flip-flops
      shift_mode = 0; capture_req = 0; capture_data = 8'h3C;
      step();
      idle();
      release_hold();
      chk("R8 no capture without request", applied_vec, 8'hA5);

      // R9: illegal request flagged and ignored
      shift_mode = 1; step_en = 0; capture_req = 1; capture_data = 8'h0F;
      step();
      chk("R9 mode_err set", {7'd0, mode_err}, 8'd1);
      idle();
      step();
      chk("R9 mode_err clears", {7'd0, mode_err}, 8'd0);
      release_hold();
      chk("R9 capture data not loaded", applied_vec, 8'hA5);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule